// File: doc/BRIEF.md
# Saturating Up/Down Tap Position Controller

This block keeps the wiper tap position of a 64-position resistor divider as a 6-bit code. A host or a manual control steers it with three wires: an active-low select, a direction input and a step strobe. While the select is low, every falling edge of the strobe moves the position by one tap. A direction of 1 moves it up and a direction of 0 moves it down. The position stops at the end codes and never wraps.

The block runs on a system clock. All three control wires come from outside that clock domain, so each passes through a synchroniser of the same depth. A falling edge of the synchronised strobe becomes a single-cycle step request. Direction and select are taken from the synchronised copies in that same cycle. Reset puts the position at mid-scale, code 32, which leaves 31 steps up and 32 steps down. Besides the code, the block drives a 64-bit one-hot vector that selects the switch of the active tap.

Top module: `tap_step_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the code reads 32 (6'b100000) and only bit 32 of the tap vector is set.
- R2: Only a falling edge of the strobe causes a step. A rising edge or a steady strobe level leaves the code unchanged.
- R3: While the select input is high (deselected), strobe falling edges leave the code unchanged for both direction values.
- R4: With select low, a falling strobe edge with direction 1 adds one to the code, and one with direction 0 subtracts one.
- R5: When the code is 63, a step with direction 1 keeps it at 63.
- R6: When the code is 0, a step with direction 0 keeps it at 0.
- R7: A strobe held low for many clock cycles gives exactly one step, and consecutive step requests are never granted on adjacent cycles.
- R8: The tap vector always has exactly one bit set, at the index equal to the code, and it changes in the same cycle as the code.
- R9: With two synchroniser stages, a strobe fall made between two rising clock edges changes the code at the third rising edge after it. The code is unchanged after the first and second edges.
- R10: Direction and select use the same synchroniser depth as the strobe. A direction value applied at the moment the strobe falls is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low select from outside the clock domain |
| dir_i | input | 1 | Step direction: 1 up, 0 down |
| strobe_i | input | 1 | Step strobe; each falling edge is one step request |
| code_o | output | 6 | Current tap position code |
| tap_o | output | 64 | One-hot tap switch select, bit index equals code |

## Verification
Assertions check on every cycle that the tap vector is one-hot and that no step request follows another on the next cycle. They also check that the code holds when no step is requested, that it moves by exactly one away from the end codes, and that it holds at 63 and at 0 under a step toward the end. Only the bench scenarios can show how the raw wires map to steps. These are the three-edge latency from a strobe fall and that a rising edge does nothing. They also include the blocking effect of a high select, a single step for a long low pulse, a direction change made together with the strobe fall, and a full sweep from mid-scale to both end codes.

// File: rtl/tap_step_pkg.sv
package tap_step_pkg;

   // Direction encoding seen by the counter
   typedef enum logic {
      STEP_DOWN = 1'b0,
      STEP_UP   = 1'b1
   } step_dir_e;

   // One step request
   typedef struct packed {
      logic      valid;
      step_dir_e dir;
   } step_req_t;

endpackage

// File: rtl/tap_sync.sv
module tap_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tap_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tap_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[g] <= RST_VAL;
               else        stage_q[g] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[g] <= RST_VAL;
               else        stage_q[g] <= stage_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tap_edge.sv
module tap_edge
   import tap_step_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe_s,
   input  logic      sel_n_s,
   input  logic      dir_s,
   output step_req_t req_o
);

   logic strobe_prev_q;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_prev_q <= 1'b0;
      else        strobe_prev_q <= strobe_s;
   end

   assign fall      = strobe_prev_q & ~strobe_s;
   assign req_o.valid = fall & ~sel_n_s;
   assign req_o.dir   = dir_s ? STEP_UP : STEP_DOWN;

   // R7
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_o.valid |=> !req_o.valid);

   // R3
   sel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_s |-> !req_o.valid);

endmodule

// File: rtl/tap_counter.sv
module tap_counter
   import tap_step_pkg::*;
#(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_req_t        req_i,
   output logic [WIDTH-1:0] code_o
);

   localparam logic [WIDTH-1:0] MAX_CODE = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] MIN_CODE = '0;
   localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < 2 || WIDTH > 10) begin : g_bad_width
         $error("tap_counter: WIDTH must be 2..10");
      end
   endgenerate

   logic [WIDTH-1:0] code_q;
   logic [WIDTH-1:0] code_d;
   logic             at_top;
   logic             at_bot;

   assign at_top = (code_q == MAX_CODE);
   assign at_bot = (code_q == MIN_CODE);

   always_comb begin
      code_d = code_q;
      if (req_i.valid) begin
         if (req_i.dir == STEP_UP) begin
            if (!at_top) code_d = code_q + 1'b1;
         end else begin
            if (!at_bot) code_d = code_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= MID_CODE;
      else        code_q <= code_d;
   end

   assign code_o = code_q;

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i.valid |=> $stable(code_q));

   // R4
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i.valid && req_i.dir == STEP_UP && code_q != MAX_CODE)
      |=> (code_q == $past(code_q) + 1'b1));

   // R4
   down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i.valid && req_i.dir == STEP_DOWN && code_q != MIN_CODE)
      |=> (code_q == $past(code_q) - 1'b1));

   // R5
   top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i.valid && req_i.dir == STEP_UP && code_q == MAX_CODE)
      |=> (code_q == MAX_CODE));

   // R6
   bot_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i.valid && req_i.dir == STEP_DOWN && code_q == MIN_CODE)
      |=> (code_q == MIN_CODE));

endmodule

// File: rtl/tap_decode.sv
module tap_decode #(
   parameter int WIDTH = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WIDTH-1:0]     code_i,
   output logic [2**WIDTH-1:0]  tap_o
);

   localparam int TAPS = 2**WIDTH;

   genvar i;
   generate
      for (i = 0; i < TAPS; i++) begin : g_tap
         assign tap_o[i] = (code_i == WIDTH'(i));
      end
   endgenerate

   // R8
   onehot_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_o) == 1);

endmodule

// File: rtl/tap_step_ctrl.sv
module tap_step_ctrl
   import tap_step_pkg::*;
#(
   parameter int CODE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel_n_i,
   input  logic                 dir_i,
   input  logic                 strobe_i,
   output logic [CODE_W-1:0]    code_o,
   output logic [2**CODE_W-1:0] tap_o
);

   localparam int CTRL_W = 3;
   // bit 2: select (idle high), bit 1: direction, bit 0: strobe
   localparam logic [CTRL_W-1:0] CTRL_RST = 3'b100;

   logic [CTRL_W-1:0] ctrl_raw;
   logic [CTRL_W-1:0] ctrl_s;
   step_req_t         req;

   assign ctrl_raw = {sel_n_i, dir_i, strobe_i};

   tap_sync #(
      .WIDTH   (CTRL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTRL_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (ctrl_raw),
      .sync_o  (ctrl_s)
   );

   tap_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_s (ctrl_s[0]),
      .sel_n_s  (ctrl_s[2]),
      .dir_s    (ctrl_s[1]),
      .req_o    (req)
   );

   tap_counter #(
      .WIDTH (CODE_W)
   ) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req),
      .code_o (code_o)
   );

   tap_decode #(
      .WIDTH (CODE_W)
   ) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (code_o),
      .tap_o  (tap_o)
   );

endmodule

// File: tb/test_tap_step_ctrl.sv
module test_tap_step_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        dir = 1'b0;
   logic        strobe = 1'b1;
   logic [5:0]  code;
   logic [63:0] tap;

   int checks = 0;
   int errors = 0;
   int exp_code = 32;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tap_step_ctrl i_tap_step_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n_i  (sel_n),
      .dir_i    (dir),
      .strobe_i (strobe),
      .code_o   (code),
      .tap_o    (tap)
   );

   task automatic chk(input string req, input int exp);
      logic [63:0] exp_tap;
      exp_tap = 64'd1 << exp;
      checks++;
      if (code !== 6'(exp) || tap !== exp_tap) begin
         errors++;
         $display("FAIL %s: code=%0d tap=%h expected code=%0d tap=%h",
                  req, code, tap, exp, exp_tap);
      end
   endtask

   // Full strobe pulse; inputs change on falling clock edges
   task automatic pulse(input logic d, input logic s, input int low_cyc);
      @(negedge clk);
      dir = d;
      sel_n = s;
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      repeat (low_cyc) @(negedge clk);
      strobe = 1'b1;
      repeat (5) @(negedge clk);
      if (!s) begin
         if (d && exp_code < 63) exp_code++;
         else if (!d && exp_code > 0) exp_code--;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 32);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 after reset", 32);

      // R9 latency and R2 rising edge
      @(negedge clk);
      dir = 1'b1; sel_n = 1'b0;
      repeat (3) @(negedge clk);
      strobe = 1'b0;
      @(negedge clk); chk("R9 edge1", 32);
      @(negedge clk); chk("R9 edge2", 32);
      @(negedge clk); chk("R9 edge3", 33);
      exp_code = 33;
      repeat (4) @(negedge clk);
      strobe = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 rising edge ignored", 33);

      // R4 / R5 sweep up to top and beyond
      for (int k = 0; k < 40; k++) begin
         pulse(1'b1, 1'b0, 3);
         chk(exp_code == 63 ? "R5 top clamp" : "R4 up step", exp_code);
      end
      // R6 sweep down to bottom and beyond
      for (int k = 0; k < 70; k++) begin
         pulse(1'b0, 1'b0, 3);
         chk(exp_code == 0 ? "R6 bottom clamp" : "R4 down step", exp_code);
      end

      // R3 deselected, both directions
      for (int k = 0; k < 4; k++) begin
         pulse(1'b1, 1'b1, 3);
         chk("R3 deselected up", exp_code);
         pulse(1'b0, 1'b1, 3);
         chk("R3 deselected down", exp_code);
      end

      // R7 long low strobe yields one step
      pulse(1'b1, 1'b0, 40);
      chk("R7 long low one step", exp_code);
      pulse(1'b1, 1'b0, 1);
      chk("R7 short low one step", exp_code);

      // R10 direction flipped together with strobe fall
      @(negedge clk);
      dir = 1'b1; sel_n = 1'b0;
      repeat (3) @(negedge clk);
      strobe = 1'b0; dir = 1'b0;
      repeat (5) @(negedge clk);
      strobe = 1'b1;
      repeat (5) @(negedge clk);
      if (exp_code > 0) exp_code--;
      chk("R10 new direction applies", exp_code);

      // R1 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-run", 32);
      rst_n = 1'b1;
      exp_code = 32;
      repeat (3) @(negedge clk);
      pulse(1'b0, 1'b0, 3);
      chk("R4 down from mid", exp_code);

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule